// File: doc/BRIEF.md
# Three-Channel Grouped Timer Counters

Three up-counters of parameterised width sit behind a small register bus. Each channel has a run bit, a compare value, a clear-source selector and an output pin. The pin is set to an initial level, then changed by compare matches. A counter advances by one on every clock cycle in which its run bit and the shared `tick` input are both 1.

A group register marks channels as linked. The group is active only when two or more channels are marked. While it is active, a counter write to any member loads the same value into every member. A member whose clear selector asks for the group clear is zeroed whenever another member clears on its own compare match. Stopping a channel freezes its count and holds its pin level. Writing the output-control register of a stopped channel sets its pin to the programmed initial level at once.

Register map: address 0x0 is the run register and 0x1 is the group register. Channel n has four registers at 4·(n+1): +0 counter, +1 compare value, +2 clear selector, +3 output control.

Top module: `sync_timer3`

## Requirements
- R1: The group register keeps bits 2..0 (bit n marks channel n). Bits above 2 read 0 and writes to them are ignored. After reset it reads 0.
- R2: The run register keeps bits 2..0 (bit n runs channel n). Other bits read 0. After reset it reads 0, all counters read 0 and all pins are 0.
- R3: A running channel adds 1 on each cycle with `tick`=1 and wraps from all-ones to 0. A stopped channel keeps its value.
- R4: The group is active only when at least two group bits are 1. With fewer, every channel behaves independently.
- R5: While the group is active, a counter write to a member loads the written value into every member. A write to a non-member changes only that channel.
- R6: A compare match occurs in a cycle where the channel is running, `tick`=1 and the counter equals the compare value. With clear selector 1, the counter is 0 after the next edge instead of incrementing. Selectors 0 and 3 never clear. The compare value resets to all-ones.
- R7: A channel with clear selector 2 that belongs to the active group clears on the same edge as another member that clears on its own match. Outside an active group, selector 2 never clears.
- R8: When a clear and a counter write meet on the same edge, the channel reads 0 afterwards.
- R9: On a compare match the pin follows output-control bits 2..1 on the same edge: 00 hold, 01 drive 0, 10 drive 1, 11 toggle.
- R10: While a channel is stopped its pin keeps its level, whatever `tick` does.
- R11: Writing output control while the channel is stopped sets the pin to bit 0 of the written value on the write edge. While the channel runs, the write leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data (combinational from bus_addr) |
| cmp_pin | output | 3 | Compare output pins, bit n for channel n |

## Verification
A register write is visible on the read port in the cycle after its write edge. Each tick cycle moves a counter on exactly one edge. A match detected in one cycle clears the counter and drives the pin on the following edge. The bench drives inputs just after a falling edge, so n ticked cycles mean exactly n rising edges. It reads results one nanosecond after a falling edge, once every edge it counted has passed. Expected counts come from modular arithmetic over the compare value, and pin levels come from the number of matches.

// File: rtl/sync_timer3.sv
module sync_timer3 #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [2:0]    cmp_pin
);
  localparam int NCH = 3;
  localparam logic [1:0] CLR_OWN = 2'b01;
  localparam logic [1:0] CLR_GRP = 2'b10;

  logic [NCH-1:0] start_q, sync_q, grp;
  logic [CW-1:0]  cnt_q [NCH];
  logic [CW-1:0]  cmp_q [NCH];
  logic [1:0]     csel_q [NCH];
  logic [2:0]     ocr_q [NCH];
  logic [NCH-1:0] run, match, own_clr, clr, cnt_wr, ld, ocr_wr;
  logic           grp_clr, grp_ld;

  assign grp     = ($countones(sync_q) >= 2) ? sync_q : '0;
  assign grp_clr = |(own_clr & grp);
  assign grp_ld  = |(cnt_wr & grp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      sync_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == 4'd0) start_q <= bus_wdata[NCH-1:0];
      if (bus_addr == 4'd1) sync_q  <= bus_wdata[NCH-1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [3:0] BASE = 4'((n + 1) * 4);

    assign run[n]     = start_q[n] & tick;
    assign match[n]   = run[n] && (cnt_q[n] == cmp_q[n]);
    assign own_clr[n] = match[n] && (csel_q[n] == CLR_OWN);
    assign clr[n]     = own_clr[n] | (grp[n] && (csel_q[n] == CLR_GRP) && grp_clr);
    assign cnt_wr[n]  = bus_wr && (bus_addr == BASE);
    assign ld[n]      = cnt_wr[n] | (grp[n] & grp_ld);
    assign ocr_wr[n]  = bus_wr && (bus_addr == BASE + 4'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[n]  <= '0;
        cmp_q[n]  <= '1;
        csel_q[n] <= '0;
        ocr_q[n]  <= '0;
        cmp_pin[n] <= 1'b0;
      end else begin
        if (clr[n])      cnt_q[n] <= '0;
        else if (ld[n])  cnt_q[n] <= bus_wdata;
        else if (run[n]) cnt_q[n] <= cnt_q[n] + CW'(1);
        if (bus_wr && bus_addr == BASE + 4'd1) cmp_q[n]  <= bus_wdata;
        if (bus_wr && bus_addr == BASE + 4'd2) csel_q[n] <= bus_wdata[1:0];
        if (ocr_wr[n]) ocr_q[n] <= bus_wdata[2:0];
        if (ocr_wr[n] && !start_q[n]) cmp_pin[n] <= bus_wdata[0];
        else if (match[n]) begin
          case (ocr_q[n][2:1])
            2'b01:   cmp_pin[n] <= 1'b0;
            2'b10:   cmp_pin[n] <= 1'b1;
            2'b11:   cmp_pin[n] <= ~cmp_pin[n];
            default: cmp_pin[n] <= cmp_pin[n];
          endcase
        end
      end
    end

    a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[n] && !ld[n] && !clr[n]) |=> $stable(cnt_q[n]));
    a_r6_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
      own_clr[n] |=> (cnt_q[n] == '0));
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[n] && ld[n]) |=> (cnt_q[n] == '0));
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (match[n] && ocr_q[n][2:1] == 2'b11) |=> (cmp_pin[n] != $past(cmp_pin[n])));
    a_r10_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[n] && !ocr_wr[n]) |=> $stable(cmp_pin[n]));
  end

  a_r5_group_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr[0] && grp[0] && grp[1] && !clr[1]) |=> (cnt_q[1] == $past(bus_wdata)));
  a_r4_lone_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sync_q) < 2 && cnt_wr[0] && !clr[1] && !run[1]) |=> $stable(cnt_q[1]));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 4'd0) bus_rdata[NCH-1:0] = start_q;
    else if (bus_addr == 4'd1) bus_rdata[NCH-1:0] = sync_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr[3:2] == 2'(n + 1)) begin
        case (bus_addr[1:0])
          2'd0: bus_rdata = cnt_q[n];
          2'd1: bus_rdata = cmp_q[n];
          2'd2: bus_rdata[1:0] = csel_q[n];
          default: bus_rdata[2:0] = ocr_q[n];
        endcase
      end
    end
  end
endmodule

// File: tb/sync_timer3_tb.sv
module sync_timer3_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [CW-1:0] bus_wdata = 0;
  logic [CW-1:0] bus_rdata;
  logic [2:0] cmp_pin;
  int checks = 0, failures = 0;
  bit done = 0;

  sync_timer3 #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_pin(cmp_pin)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = CW'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 4'(a);
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic ticks(input int k);
    tick = 1;
    repeat (k) @(negedge clk);
    tick = 0;
  endtask

  function automatic int cnt_a(input int n);
    return (n + 1) * 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 / R1 reset state
    rd(0, v); chk("R2 run reset", v, 0);
    rd(1, v); chk("R1 group reset", v, 0);
    for (int n = 0; n < 3; n++) begin
      rd(cnt_a(n), v); chk("R2 counter reset", v, 0);
      rd(cnt_a(n) + 1, v); chk("R6 compare reset", v, 16'hFFFF);
    end
    chk("R2 pins reset", int'(cmp_pin), 0);

    // R1 upper bits ignored
    wr(1, 16'hFFFF); rd(1, v); chk("R1 group upper bits", v, 7);
    wr(0, 16'hFFF8); rd(0, v); chk("R2 run upper bits", v, 0);
    wr(1, 0);

    // R3 sweep over run masks
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 3; n++) wr(cnt_a(n), 0);
      wr(0, m);
      ticks(m + 2);
      wr(0, 0);
      ticks(3);
      for (int n = 0; n < 3; n++) begin
        rd(cnt_a(n), v); chk("R3 count per run mask", v, ((m >> n) & 1) ? m + 2 : 0);
      end
    end
    wr(cnt_a(1), 16'hFFFE); wr(0, 2); ticks(3); wr(0, 0);
    rd(cnt_a(1), v); chk("R3 wrap", v, 1);

    // R4 / R5 group-load sweep
    for (int m = 0; m < 8; m++) begin
      for (int t = 0; t < 3; t++) begin
        bit act;
        wr(1, 0);
        for (int n = 0; n < 3; n++) wr(cnt_a(n), 100 * (n + 1));
        wr(1, m);
        wr(cnt_a(t), 1000 + t);
        act = ($countones(3'(m)) >= 2) && ((m >> t) & 1);
        for (int n = 0; n < 3; n++) begin
          int e;
          if (n == t) e = 1000 + t;
          else if (act && ((m >> n) & 1)) e = 1000 + t;
          else e = 100 * (n + 1);
          rd(cnt_a(n), v); chk("R4 R5 group load", v, e);
        end
      end
    end
    wr(1, 0);

    // R6 / R9 / R11 own-match clear with toggle, compare 5
    wr(cnt_a(0) + 1, 5);
    for (int s = 0; s < 2; s++) begin
      wr(cnt_a(0) + 2, s == 0 ? 1 : 0);
      for (int k = 0; k < 15; k++) begin
        wr(0, 0);
        wr(cnt_a(0) + 3, 6);
        chk("R11 init level while stopped", int'(cmp_pin[0]), 0);
        wr(cnt_a(0), 0);
        wr(0, 1);
        ticks(k);
        wr(0, 0);
        rd(cnt_a(0), v);
        if (s == 0) begin
          chk("R6 own clear count", v, k % 6);
          chk("R9 toggle count", int'(cmp_pin[0]), (k / 6) % 2);
        end else begin
          chk("R6 selector 0 no clear", v, k);
          chk("R9 toggle once", int'(cmp_pin[0]), k >= 6 ? 1 : 0);
        end
      end
    end
    wr(cnt_a(0) + 2, 3); wr(cnt_a(0), 0); wr(0, 1); ticks(8); wr(0, 0);
    rd(cnt_a(0), v); chk("R6 selector 3 no clear", v, 8);

    // R7 group clear
    wr(cnt_a(0) + 1, 3); wr(cnt_a(0) + 2, 1);
    wr(cnt_a(1) + 2, 2); wr(cnt_a(2) + 2, 2);
    wr(1, 3);
    for (int k = 0; k < 10; k++) begin
      wr(cnt_a(0), 0); wr(cnt_a(2), 0);
      wr(0, 7); ticks(k); wr(0, 0);
      rd(cnt_a(0), v); chk("R7 leader count", v, k % 4);
      rd(cnt_a(1), v); chk("R7 member group clear", v, k % 4);
      rd(cnt_a(2), v); chk("R7 non-member no clear", v, k);
    end
    wr(1, 1);
    wr(cnt_a(0), 0); wr(cnt_a(1), 0);
    wr(0, 3); ticks(9); wr(0, 0);
    rd(cnt_a(1), v); chk("R7 R4 lone bit no group clear", v, 9);
    wr(1, 0);

    // R8 clear beats write
    wr(cnt_a(0) + 1, 2); wr(cnt_a(0) + 2, 1); wr(cnt_a(0), 0); wr(0, 1);
    tick = 1;
    repeat (2) @(negedge clk);
    bus_wr = 1; bus_addr = 4'(cnt_a(0)); bus_wdata = 16'h77;
    @(negedge clk);
    bus_wr = 0; tick = 0;
    rd(cnt_a(0), v); chk("R8 clear wins over write", v, 0);
    wr(0, 0);

    // R9 / R10 / R11 drive-high action and hold
    wr(cnt_a(0) + 3, 4); wr(cnt_a(0) + 2, 0); wr(cnt_a(0), 0);
    wr(0, 1); ticks(3);
    chk("R9 drive high on match", int'(cmp_pin[0]), 1);
    wr(cnt_a(0) + 3, 4);
    chk("R11 running write keeps pin", int'(cmp_pin[0]), 1);
    wr(0, 0);
    rd(cnt_a(0), v);
    ticks(5);
    chk("R10 stopped pin hold", int'(cmp_pin[0]), 1);
    begin int v2; rd(cnt_a(0), v2); chk("R3 stopped count hold", v2, v); end
    wr(cnt_a(0) + 3, 4);
    chk("R11 stopped write low", int'(cmp_pin[0]), 0);
    wr(cnt_a(0) + 3, 5);
    chk("R11 stopped write high", int'(cmp_pin[0]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule